// File: doc/BRIEF.md
# Audio Tick Scheduler with DMA Countdown

The block turns a free-running host clock count into fixed-length audio ticks. The host presents its current count with a valid strobe. The block compares each accepted count with the point it has already consumed, keeps the unconsumed clocks as a backlog, and then issues one tick for each full tick period in that backlog. It issues at most one tick per clock cycle. A backward step of the host clock by a few clocks is ignored. A very large forward difference is clamped, so that a burst of ticks can never run away.

Every tick does the following work:

- It delivers any pending interrupt request as a single pulse.
- It advances each DMA completion countdown. Channels are started with a length and a target address. While a channel's count stays positive, its memory address moves forward by a fixed step. When the count runs out, the address is loaded with the target and a completion pulse is raised.
- It increments a tick counter.
- It raises a mix strobe one cycle later, after the DMA updates.

Top module: `tick_sched`

## Requirements
- R1: After reset all pulses are low, and the tick counter and every DMA memory address are zero.
- R2: On an accepted sample, the backlog becomes host count minus the consumed point, all modulo 2^32. One tick is produced per TICK_CLKS (768) clocks of backlog, at most one per cycle, and the consumed point advances by TICK_CLKS for each tick. The first tick_o comes one cycle after the capturing edge.
- R3: A sample whose difference from the consumed point is above 2^32-15 is ignored. This covers backward steps of 1 to 14 clocks.
- R4: A difference above TICK_CLKS*CLAMP_TICKS (3,686,400) is clamped to that value, and the consumed point is rebased to host count minus the clamp. A backward step of exactly 15 falls in this case and produces 4800 ticks.
- R5: tick_cnt_o increments by one with every tick_o and is otherwise stable.
- R6: After irq_set_i, the next tick carries exactly one irq_o pulse, in the same cycle as tick_o. The request is then cleared.
- R7: dma_start_i[c] loads the channel's count (signed) and its target, and leaves the address unchanged. On a tick with a positive count, the count is decreased by 768. If the result is still positive, the address advances by 2*TICK_CLKS (1536). The address changes only with a tick.
- R8: When the decremented count is zero or negative, the address becomes the target, the count becomes zero, and dma_done_o[c] pulses for one cycle together with tick_o.
- R9: The channels run independently. A channel started with a count of zero or less never completes and keeps its address.
- R10: mix_o pulses exactly one cycle after each tick_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_cnt_i | input | W | Free-running host clock count |
| host_vld_i | input | 1 | host_cnt_i is valid this cycle |
| irq_set_i | input | 1 | Mark an interrupt pending |
| dma_start_i | input | NUM_DMA | Start a countdown per channel |
| dma_len_i | input | NUM_DMA×W | Signed count for each channel's start |
| dma_tgt_i | input | NUM_DMA×W | Target address for each channel's start |
| tick_o | output | 1 | One-cycle tick pulse |
| tick_cnt_o | output | W | Ticks since reset |
| irq_o | output | 1 | Interrupt delivered with a tick |
| mix_o | output | 1 | Mix strobe, one cycle after the tick |
| dma_done_o | output | NUM_DMA | Completion pulse per channel |
| dma_madr_o | output | NUM_DMA×W | Current memory address per channel |

## Verification
A sample captured at edge E0 gives its first tick_o, irq_o, dma_done_o and address update at edge E1. The following ticks come one per cycle, and mix_o follows each tick one edge later. The bench drives inputs on falling edges and reads outputs on falling edges. Exact-cycle checks look at the falling edge right after E1 and at each later one. Backlog checks count pulses over a window that is longer than the longest possible burst before comparing them with the bench model.

// File: rtl/tick_sched_pkg.sv
package tick_sched_pkg;
  localparam int unsigned DEF_W           = 32;
  localparam int unsigned DEF_TICK_CLKS   = 768;
  localparam int unsigned DEF_CLAMP_TICKS = 4800;
  localparam int unsigned DEF_BACK_TOL    = 15;
  localparam int unsigned DEF_NUM_DMA     = 2;
endpackage

// File: rtl/tick_clk_tracker.sv
module tick_clk_tracker #(
  parameter int unsigned W           = 32,
  parameter int unsigned TICK_CLKS   = 768,
  parameter int unsigned CLAMP_TICKS = 4800,
  parameter int unsigned BACK_TOL    = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] host_cnt_i,
  input  logic         host_vld_i,
  output logic         tick_req_o
);
  localparam logic [W-1:0] TICK_L  = W'(TICK_CLKS);
  localparam logic [W-1:0] LIMIT_L = W'(TICK_CLKS * CLAMP_TICKS);
  localparam logic [W-1:0] BACK_L  = '0 - W'(BACK_TOL);

  logic [W-1:0] cons_q, cons_d, bl_q, bl_d;
  logic [W-1:0] cons_adv, bl_adv, delta;
  logic         tick;

  always_comb begin
    tick     = (bl_q >= TICK_L);
    cons_adv = tick ? cons_q + TICK_L : cons_q;
    bl_adv   = tick ? bl_q - TICK_L : bl_q;
    delta    = host_cnt_i - cons_adv;
    cons_d   = cons_adv;
    bl_d     = bl_adv;
    if (host_vld_i) begin
      if (delta > BACK_L) begin
        // small backward step: keep state
        bl_d = bl_adv;
      end else if (delta > LIMIT_L) begin
        bl_d   = LIMIT_L;
        cons_d = host_cnt_i - LIMIT_L;
      end else begin
        bl_d = delta;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cons_q <= '0;
      bl_q   <= '0;
    end else begin
      cons_q <= cons_d;
      bl_q   <= bl_d;
    end
  end

  assign tick_req_o = tick;
endmodule

// File: rtl/tick_irq_gate.sv
module tick_irq_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_set_i,
  input  logic tick_i,
  output logic irq_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      irq_o <= tick_i & pend_q;
      if (irq_set_i)   pend_q <= 1'b1;
      else if (tick_i) pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tick_dma_chan.sv
module tick_dma_chan #(
  parameter int unsigned W         = 32,
  parameter int unsigned TICK_CLKS = 768
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] len_i,
  input  logic [W-1:0] tgt_i,
  input  logic         tick_i,
  output logic         done_o,
  output logic [W-1:0] madr_o
);
  localparam logic [W-1:0] TICK_L = W'(TICK_CLKS);
  localparam logic [W-1:0] STEP_L = W'(2 * TICK_CLKS);

  logic [W-1:0] cnt_q, tgt_q, nxt;
  logic         active, expire;

  always_comb begin
    active = !cnt_q[W-1] && (cnt_q != '0);
    nxt    = cnt_q - TICK_L;
    expire = nxt[W-1] || (nxt == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tgt_q  <= '0;
      madr_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        cnt_q <= len_i;
        tgt_q <= tgt_i;
      end else if (tick_i && active) begin
        if (expire) begin
          madr_o <= tgt_q;
          cnt_q  <= '0;
          done_o <= 1'b1;
        end else begin
          madr_o <= madr_o + STEP_L;
          cnt_q  <= nxt;
        end
      end
    end
  end
endmodule

// File: rtl/tick_sched.sv
module tick_sched
  import tick_sched_pkg::*;
#(
  parameter int unsigned W           = DEF_W,
  parameter int unsigned TICK_CLKS   = DEF_TICK_CLKS,
  parameter int unsigned CLAMP_TICKS = DEF_CLAMP_TICKS,
  parameter int unsigned BACK_TOL    = DEF_BACK_TOL,
  parameter int unsigned NUM_DMA     = DEF_NUM_DMA
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [W-1:0]                  host_cnt_i,
  input  logic                          host_vld_i,
  input  logic                          irq_set_i,
  input  logic [NUM_DMA-1:0]            dma_start_i,
  input  logic [NUM_DMA-1:0][W-1:0]     dma_len_i,
  input  logic [NUM_DMA-1:0][W-1:0]     dma_tgt_i,
  output logic                          tick_o,
  output logic [W-1:0]                  tick_cnt_o,
  output logic                          irq_o,
  output logic                          mix_o,
  output logic [NUM_DMA-1:0]            dma_done_o,
  output logic [NUM_DMA-1:0][W-1:0]     dma_madr_o
);
  logic tick_req;

  tick_clk_tracker #(
    .W(W), .TICK_CLKS(TICK_CLKS), .CLAMP_TICKS(CLAMP_TICKS), .BACK_TOL(BACK_TOL)
  ) u_trk (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .host_cnt_i(host_cnt_i), .host_vld_i(host_vld_i),
    .tick_req_o(tick_req)
  );

  tick_irq_gate u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .irq_set_i(irq_set_i), .tick_i(tick_req), .irq_o(irq_o)
  );

  for (genvar c = 0; c < NUM_DMA; c++) begin : g_dma
    tick_dma_chan #(.W(W), .TICK_CLKS(TICK_CLKS)) u_ch (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .start_i(dma_start_i[c]), .len_i(dma_len_i[c]), .tgt_i(dma_tgt_i[c]),
      .tick_i(tick_req),
      .done_o(dma_done_o[c]), .madr_o(dma_madr_o[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_o     <= 1'b0;
      mix_o      <= 1'b0;
      tick_cnt_o <= '0;
    end else begin
      tick_o <= tick_req;
      mix_o  <= tick_o;  // after DMA state has settled
      if (tick_req) tick_cnt_o <= tick_cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/tick_sched_chk.sv
module tick_sched_chk #(
  parameter int unsigned W       = 32,
  parameter int unsigned NUM_DMA = 2
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      tick_o,
  input logic [W-1:0]              tick_cnt_o,
  input logic                      irq_o,
  input logic                      mix_o,
  input logic [NUM_DMA-1:0]        dma_done_o,
  input logic [NUM_DMA-1:0][W-1:0] dma_madr_o
);
  // R5
  tick_cnt_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> tick_cnt_o == $past(tick_cnt_o) + 1'b1);
  // R5
  tick_cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |-> $stable(tick_cnt_o));
  // R6
  irq_with_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> tick_o);
  // R10
  mix_follows_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> mix_o);
  // R10
  mix_only_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mix_o |-> $past(tick_o));

  for (genvar c = 0; c < NUM_DMA; c++) begin : g_chk
    // R8
    done_with_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dma_done_o[c] |-> tick_o);
    // R8
    done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dma_done_o[c] |=> !dma_done_o[c]);
    // R7
    madr_only_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_o |-> $stable(dma_madr_o[c]));
  end
endmodule

bind tick_sched tick_sched_chk #(.W(W), .NUM_DMA(NUM_DMA)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick_o), .tick_cnt_o(tick_cnt_o),
  .irq_o(irq_o), .mix_o(mix_o), .dma_done_o(dma_done_o), .dma_madr_o(dma_madr_o)
);

// File: tb/tick_sched_test.sv
module tick_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int ND = 2;
  localparam logic [31:0] TICK = 32'd768;
  localparam logic [31:0] LIMIT = 32'd3686400;
  localparam logic [31:0] BACK = 32'hFFFF_FFF1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [W-1:0] host_cnt = '0;
  logic host_vld = 1'b0;
  logic irq_set = 1'b0;
  logic [ND-1:0] dma_start = '0;
  logic [ND-1:0][W-1:0] dma_len = '0;
  logic [ND-1:0][W-1:0] dma_tgt = '0;
  logic tick_o, irq_o, mix_o;
  logic [W-1:0] tick_cnt_o;
  logic [ND-1:0] dma_done_o;
  logic [ND-1:0][W-1:0] dma_madr_o;

  tick_sched uut (
    .clk_i(clk), .rst_ni(rst_ni), .host_cnt_i(host_cnt), .host_vld_i(host_vld),
    .irq_set_i(irq_set), .dma_start_i(dma_start), .dma_len_i(dma_len),
    .dma_tgt_i(dma_tgt), .tick_o(tick_o), .tick_cnt_o(tick_cnt_o), .irq_o(irq_o),
    .mix_o(mix_o), .dma_done_o(dma_done_o), .dma_madr_o(dma_madr_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int tick_seen = 0, irq_seen = 0, mix_err = 0;
  int done_seen [ND];
  logic prev_tick = 1'b0;
  logic [31:0] exp_cons = '0, exp_bl = '0, exp_cnt = '0;
  int cyc = 0;

  initial for (int c = 0; c < ND; c++) done_seen[c] = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_ni) begin
      if (tick_o) tick_seen++;
      if (irq_o) irq_seen++;
      for (int c = 0; c < ND; c++) if (dma_done_o[c]) done_seen[c]++;
      if (mix_o !== prev_tick) mix_err++;
      prev_tick = tick_o;
    end
  end

  initial begin
    while (cyc < 150000) @(negedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog act=%0d exp=<150000 cycles", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  // expected tick count for a sample, from R2/R3/R4
  function automatic int model_sample(input logic [31:0] h);
    logic [31:0] d;
    int t;
    d = h - exp_cons;
    if (d > BACK) begin
      // ignored
    end else if (d > LIMIT) begin
      exp_bl = LIMIT;
      exp_cons = h - LIMIT;
    end else begin
      exp_bl = d;
    end
    t = int'(exp_bl / TICK);
    exp_cons = exp_cons + TICK * 32'(t);
    exp_bl = exp_bl % TICK;
    exp_cnt = exp_cnt + 32'(t);
    return t;
  endfunction

  task automatic sample(input logic [31:0] h);
    @(negedge clk);
    host_cnt = h; host_vld = 1'b1;
    @(negedge clk);
    host_vld = 1'b0;
  endtask

  task automatic run_sample(input string req, input logic [31:0] h, input int wait_c);
    int e;
    tick_seen = 0;
    e = model_sample(h);
    sample(h);
    repeat (wait_c) @(negedge clk);
    chk(req, 32'(tick_seen), 32'(e));
  endtask

  initial begin
    logic [31:0] h;
    int e, r;
    logic pend;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 tick", {31'd0, tick_o}, 0);
    chk("R1 cnt", tick_cnt_o, 0);
    chk("R1 irq_mix", {30'd0, irq_o, mix_o}, 0);
    chk("R1 madr0", dma_madr_o[0], 0);
    chk("R1 madr1", dma_madr_o[1], 0);
    chk("R1 done", {30'd0, dma_done_o}, 0);

    // R2: 3940 clocks -> 5 ticks, first one edge after capture
    tick_seen = 0;
    e = model_sample(32'd3940);
    sample(32'd3940);
    chk("R2 no tick at capture", {31'd0, tick_o}, 0);
    @(negedge clk);
    chk("R2 first tick", {31'd0, tick_o}, 1);
    repeat (4) begin
      @(negedge clk);
      chk("R2 one per cycle", {31'd0, tick_o}, 1);
    end
    @(negedge clk);
    chk("R2 stop", {31'd0, tick_o}, 0);
    repeat (3) @(negedge clk);
    chk("R2 count", 32'(tick_seen), 5);
    chk("R5 cnt", tick_cnt_o, 5);
    @(negedge clk);
    chk("R10 mix", {31'd0, mix_o}, 0);

    // R3: backward by 10 from consumed point 3840 is ignored
    run_sample("R3 back10", 32'd3830, 20);
    chk("R3 back10 none", 32'(tick_seen), 0);
    run_sample("R2 767", 32'd4607, 6);
    run_sample("R2 768", 32'd4608, 6);
    chk("R2 768 one", 32'(tick_seen), 1);

    // R4: backward by exactly 15 is clamped -> 4800 ticks
    run_sample("R4 back15", 32'd4593, 4810);
    chk("R4 back15 4800", 32'(tick_seen), 4800);
    run_sample("R4 rebase", 32'd4593 + 32'd768, 6);
    chk("R4 rebase one", 32'(tick_seen), 1);
    // R4: huge forward jump
    h = exp_cons + LIMIT + 32'd5000;
    run_sample("R4 forward", h, 4810);
    chk("R4 forward 4800", 32'(tick_seen), 4800);
    run_sample("R4 rebase2", h + 32'd768, 6);
    chk("R5 cnt after clamp", tick_cnt_o, exp_cnt);

    // R6: interrupt delivered with next tick
    irq_seen = 0;
    @(negedge clk); irq_set = 1'b1;
    @(negedge clk); irq_set = 1'b0;
    repeat (5) @(negedge clk);
    chk("R6 no irq without tick", 32'(irq_seen), 0);
    e = model_sample(exp_cons + 32'd768);
    sample(exp_cons);
    @(negedge clk);
    chk("R6 irq with tick", {30'd0, irq_o, tick_o}, 32'h3);
    e = model_sample(exp_cons + 32'd768);
    sample(exp_cons);
    @(negedge clk);
    chk("R6 cleared", {30'd0, irq_o, tick_o}, 32'h1);
    chk("R6 single", 32'(irq_seen), 1);

    // R7/R8/R9: ch0 len 2000 -> 3 ticks; ch1 len 768 -> 1 tick
    @(negedge clk);
    dma_start = 2'b11;
    dma_len[0] = 32'd2000; dma_tgt[0] = 32'hABC00;
    dma_len[1] = 32'd768;  dma_tgt[1] = 32'h01234;
    @(negedge clk);
    dma_start = 2'b00;
    chk("R7 start keeps madr", dma_madr_o[0], 0);
    done_seen[0] = 0; done_seen[1] = 0;
    e = model_sample(exp_cons + 32'd2304);
    sample(exp_cons);
    @(negedge clk);
    chk("R7 step1", dma_madr_o[0], 32'd1536);
    chk("R8 ch1 done", {31'd0, dma_done_o[1]}, 1);
    chk("R8 ch1 madr", dma_madr_o[1], 32'h01234);
    chk("R9 ch0 not done", {31'd0, dma_done_o[0]}, 0);
    @(negedge clk);
    chk("R7 step2", dma_madr_o[0], 32'd3072);
    @(negedge clk);
    chk("R8 ch0 target", dma_madr_o[0], 32'hABC00);
    chk("R8 ch0 done", {31'd0, dma_done_o[0]}, 1);
    repeat (4) @(negedge clk);
    chk("R8 ch0 single", 32'(done_seen[0]), 1);
    chk("R9 ch1 single", 32'(done_seen[1]), 1);
    chk("R9 ch1 madr held", dma_madr_o[1], 32'h01234);
    // R9: zero length never completes
    @(negedge clk);
    dma_start = 2'b01; dma_len[0] = 32'd0; dma_tgt[0] = 32'h55500;
    @(negedge clk);
    dma_start = 2'b00;
    run_sample("R9 zero len ticks", exp_cons + 32'd1536, 6);
    chk("R9 zero len no done", 32'(done_seen[0]), 1);
    chk("R9 zero len madr", dma_madr_o[0], 32'hABC00);

    // random: R2/R3/R6
    h = exp_cons + exp_bl;
    pend = 1'b0;
    irq_seen = 0;
    e = 0;
    for (int i = 0; i < 150; i++) begin
      r = int'($urandom % 8);
      if (r == 0) h = exp_cons - (32'd1 + ($urandom % 14));
      else h = h + ($urandom % 3000);
      if (($urandom % 4) == 0) begin
        @(negedge clk); irq_set = 1'b1;
        @(negedge clk); irq_set = 1'b0;
        pend = 1'b1;
      end
      tick_seen = 0;
      r = model_sample(h);
      if (pend && r > 0) begin e++; pend = 1'b0; end
      sample(h);
      repeat (8) @(negedge clk);
      chk("R2/R3 random ticks", 32'(tick_seen), 32'(r));
    end
    chk("R6 random irq", 32'(irq_seen), 32'(e));
    chk("R5 final cnt", tick_cnt_o, exp_cnt);
    chk("R10 mix errors", 32'(mix_err), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule